// File: doc/BRIEF.md
# SPI Host Interrupt Aggregator

This block collects the error and event conditions of an SPI host controller and folds them into two interrupt lines: one for errors, one for events. It keeps the interrupt state, interrupt enable and interrupt test registers. It also keeps the error-class enable mask, the sticky error status and the event-class enable mask. Software reaches all of these through a small word-addressed 32-bit write/read port. Reads are combinational, and a write takes effect at the next rising clock edge.

The controller core feeds the block in two ways. Error classes arrive as one-cycle set pulses. Event conditions (ready, transmit queue empty, receive queue full) arrive as levels. Every clock, the block checks whether an interrupt should latch. It latches only when that interrupt is enabled and not already pending. Once latched, the state bit stays set until software clears it by writing a 1 to it. Watermark and idle event classes can be enabled, but they never raise the event interrupt.

Top module: `spi_irq_hub`

## Requirements
- R1: After a synchronous active-low reset, the register values are as follows: interrupt state 0, interrupt enable 0, error enable 0x1F, error status 0, event enable 0. Both interrupt outputs are low.
- R2: The registers sit at these word addresses: 0 interrupt state, 1 interrupt enable, 2 interrupt test, 3 error enable, 4 error status, 5 event enable. Interrupt state, interrupt enable, error enable, error status and event enable read back their contents. Interrupt test and unused addresses read 0. Only bits [1:0] of interrupt enable, [4:0] of error enable and [5:0] of event enable are stored.
- R3: In both interrupt state and interrupt enable, bit 0 is the error interrupt and bit 1 is the event interrupt. Writing 1 to a state bit clears it. Each output is high exactly while its state bit and its enable bit are both 1.
- R4: Writing 1 to bit 0 or bit 1 of the test register sets the matching state bit at that write's clock edge. This happens only if that interrupt is enabled and not pending. With the interrupt disabled, a test write leaves the state at 0.
- R5: Error-class bits, in both error enable and error status, are: command busy 0, overflow 1, underflow 2, invalid command 3, invalid chip select 4. The error state bit sets at the edge after a cycle in which all of the following hold: the error interrupt is enabled, it is not pending, and some class has both its enable bit and its status bit at 1.
- R6: A pulse on err_set_i[k] sets error status bit k at that edge. Bit 5 is the invalid-access flag. Writing 1 to a status bit clears it, but a pulse in the same cycle as the clear leaves that bit set. The invalid-access flag never raises the error interrupt.
- R7: Event enable bits are: RX full 0, TX empty 1, RX watermark 2, TX watermark 3, ready 4, idle 5. The event state bit sets at the edge after a cycle in which all of the following hold: the event interrupt is enabled, it is not pending, and the RX-full, TX-empty or ready level is 1 with its enable bit set. Bits 2, 3 and 5 never cause it to set.
- R8: A pending state bit stays set until it is cleared by a write, even if its cause goes away. If the cause is still present after a clear, the bit sets again one edge later.
- R9: Clearing an interrupt enable bit forces its output low but keeps the state bit. Setting the enable bit again restores the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Word address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| err_set_i | input | 6 | One-cycle error-class set pulses (bit layout as error status) |
| lvl_rx_full | input | 1 | Receive queue full level |
| lvl_tx_empty | input | 1 | Transmit queue empty level |
| lvl_ready | input | 1 | Controller ready for a command level |
| irq_err_o | output | 1 | Error interrupt |
| irq_evt_o | output | 1 | Event interrupt |

## Verification
Each result has a fixed number of clock edges before it is due:
- A register write or a test write shows in read data and outputs one edge after it is driven.
- An event level causes the state bit to latch one edge after the enable write that exposes it.
- An error pulse sets its status bit at the first edge and the error state bit at the second.

The bench drives inputs on falling edges and samples exactly that many edges later. It sweeps every error-enable mask against every error class, and every event-enable mask against every combination of the three levels. Directed sequences cover the clear/pulse collision, re-latching after a clear, and masking while a bit is pending.

// File: rtl/spi_irq_pkg.sv
// Package: shared register addresses and bit positions of the interrupt aggregator.
// Assumes word addressing; every field position here is decoded by software.
package spi_irq_pkg;
    localparam int REG_AW = 3;
    localparam int IRQ_W  = 2;
    localparam int ERR_W  = 6;   // five enabled classes plus the access flag
    localparam int ERR_EN = 5;   // classes that carry an enable bit
    localparam int EVT_W  = 6;

    localparam int IRQ_ERR = 0;
    localparam int IRQ_EVT = 1;

    localparam int EVT_RXFULL  = 0;
    localparam int EVT_TXEMPTY = 1;
    localparam int EVT_READY   = 4;

    typedef enum logic [REG_AW-1:0] {
        A_STATE    = 3'd0,
        A_ENABLE   = 3'd1,
        A_TEST     = 3'd2,
        A_ERR_EN   = 3'd3,
        A_ERR_STAT = 3'd4,
        A_EVT_EN   = 3'd5
    } reg_addr_e;
endpackage

// File: rtl/spi_irq_errbank.sv
// Error bank: holds the per-class error enable mask and the sticky error status.
// Assumes set pulses last one cycle; a pulse wins over a clear in the same cycle.
// Bits at and above EN_W have no enable and never contribute to cause_o.
module spi_irq_errbank #(
    parameter int ERR_W = 6,
    parameter int EN_W  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_we,
    input  logic             stat_we,
    input  logic [ERR_W-1:0] wdata,
    input  logic [ERR_W-1:0] set_i,
    output logic [EN_W-1:0]  en_o,
    output logic [ERR_W-1:0] stat_o,
    output logic             cause_o
);
    logic [EN_W-1:0]  en_q;
    logic [ERR_W-1:0] stat_q;
    logic [ERR_W-1:0] clr_mask;

    // Write-1-to-clear mask, active only on a status write.
    always_comb clr_mask = stat_we ? wdata : '0;

    // Enable mask register: all classes on after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '1;
        else if (en_we) en_q <= wdata[EN_W-1:0];
    end

    // Sticky status: clear requested bits, then apply this cycle's pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr_mask) | set_i;
    end

    // Any class with both enable and status raised.
    always_comb cause_o = |(en_q & stat_q[EN_W-1:0]);

    assign en_o   = en_q;
    assign stat_o = stat_q;

    // R6: every pulsed bit is present in status one edge later.
    a_r6_pulse_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((stat_q & $past(set_i)) == $past(set_i)));

    // R6: a status bit only rises after a pulse on that bit.
    a_r6_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(set_i)) == '0));
endmodule

// File: rtl/spi_irq_evtsel.sv
// Event selector: holds the event enable mask and maps the controller levels onto it.
// Assumes only the RX-full, TX-empty and ready positions carry a live condition;
// the remaining enable bits are stored but never fire.
module spi_irq_evtsel #(
    parameter int EVT_W   = 6,
    parameter int POS_RXF = 0,
    parameter int POS_TXE = 1,
    parameter int POS_RDY = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [EVT_W-1:0] wdata,
    input  logic             rx_full,
    input  logic             tx_empty,
    input  logic             ready,
    output logic [EVT_W-1:0] en_o,
    output logic             cause_o
);
    logic [EVT_W-1:0] en_q;
    logic [EVT_W-1:0] lvl;

    // Place each live level at its enable position; silent classes stay 0.
    for (genvar i = 0; i < EVT_W; i++) begin : g_lvl
        if (i == POS_RXF)      begin : g_rxf assign lvl[i] = rx_full;  end
        else if (i == POS_TXE) begin : g_txe assign lvl[i] = tx_empty; end
        else if (i == POS_RDY) begin : g_rdy assign lvl[i] = ready;    end
        else                   begin : g_off assign lvl[i] = 1'b0;     end
    end

    // Event enable mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)  en_q <= '0;
        else if (we) en_q <= wdata;
    end

    // Any enabled live condition.
    always_comb cause_o = |(en_q & lvl);

    assign en_o = en_q;
endmodule

// File: rtl/spi_irq_line.sv
// Interrupt line: one pending bit with latch-when-idle semantics and an output gate.
// Assumes clear_i and test_i are single-cycle write decodes from the register port.
module spi_irq_line (
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  logic cause_i,
    input  logic test_i,
    input  logic clear_i,
    output logic pending_o,
    output logic irq_o
);
    logic pend_q;
    logic fire;

    // Latch only when enabled and idle; a test write counts as a cause.
    always_comb fire = enable_i & ~pend_q & (cause_i | test_i);

    // Pending bit: set on fire, cleared by write-1.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= fire | (pend_q & ~clear_i);
    end

    // Output gated by enable.
    always_comb irq_o = pend_q & enable_i;

    assign pending_o = pend_q;

    // R8: a pending bit is kept unless cleared.
    a_r8_hold_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !clear_i) |=> pend_q);

    // R4: nothing latches while the interrupt is disabled.
    a_r4_no_set_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable_i && !pend_q) |=> !pend_q);
endmodule

// File: rtl/spi_irq_hub.sv
// Top: register decode, read-back mux and two interrupt lines (error, event).
// Assumes a word-addressed write port and combinational reads without side effects.
module spi_irq_hub
    import spi_irq_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [ERR_W-1:0]  err_set_i,
    input  logic              lvl_rx_full,
    input  logic              lvl_tx_empty,
    input  logic              lvl_ready,
    output logic              irq_err_o,
    output logic              irq_evt_o
);
    logic [IRQ_W-1:0]  irq_en_q;
    logic [IRQ_W-1:0]  pending;
    logic [IRQ_W-1:0]  irq_vec;
    logic [IRQ_W-1:0]  cause;
    logic [IRQ_W-1:0]  test_hit;
    logic [IRQ_W-1:0]  clr_hit;
    logic [ERR_EN-1:0] err_en;
    logic [ERR_W-1:0]  err_stat;
    logic [EVT_W-1:0]  evt_en;
    logic              wr_state, wr_en, wr_test, wr_err_en, wr_err_stat, wr_evt_en;

    // Address decode of the write strobe.
    always_comb begin
        wr_state    = reg_we && (reg_addr == A_STATE);
        wr_en       = reg_we && (reg_addr == A_ENABLE);
        wr_test     = reg_we && (reg_addr == A_TEST);
        wr_err_en   = reg_we && (reg_addr == A_ERR_EN);
        wr_err_stat = reg_we && (reg_addr == A_ERR_STAT);
        wr_evt_en   = reg_we && (reg_addr == A_EVT_EN);
    end

    // Per-line test and clear pulses.
    always_comb begin
        test_hit = wr_test  ? reg_wdata[IRQ_W-1:0] : '0;
        clr_hit  = wr_state ? reg_wdata[IRQ_W-1:0] : '0;
    end

    // Interrupt enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)     irq_en_q <= '0;
        else if (wr_en) irq_en_q <= reg_wdata[IRQ_W-1:0];
    end

    spi_irq_errbank #(.ERR_W(ERR_W), .EN_W(ERR_EN)) u_err (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_we   (wr_err_en),
        .stat_we (wr_err_stat),
        .wdata   (reg_wdata[ERR_W-1:0]),
        .set_i   (err_set_i),
        .en_o    (err_en),
        .stat_o  (err_stat),
        .cause_o (cause[IRQ_ERR])
    );

    spi_irq_evtsel #(
        .EVT_W(EVT_W), .POS_RXF(EVT_RXFULL), .POS_TXE(EVT_TXEMPTY), .POS_RDY(EVT_READY)
    ) u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (wr_evt_en),
        .wdata    (reg_wdata[EVT_W-1:0]),
        .rx_full  (lvl_rx_full),
        .tx_empty (lvl_tx_empty),
        .ready    (lvl_ready),
        .en_o     (evt_en),
        .cause_o  (cause[IRQ_EVT])
    );

    // One pending line per interrupt.
    for (genvar i = 0; i < IRQ_W; i++) begin : g_line
        spi_irq_line u_line (
            .clk       (clk),
            .rst_n     (rst_n),
            .enable_i  (irq_en_q[i]),
            .cause_i   (cause[i]),
            .test_i    (test_hit[i]),
            .clear_i   (clr_hit[i]),
            .pending_o (pending[i]),
            .irq_o     (irq_vec[i])
        );
    end

    assign irq_err_o = irq_vec[IRQ_ERR];
    assign irq_evt_o = irq_vec[IRQ_EVT];

    // Read-back mux; test register and holes read zero.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_STATE:    reg_rdata[IRQ_W-1:0]  = pending;
            A_ENABLE:   reg_rdata[IRQ_W-1:0]  = irq_en_q;
            A_ERR_EN:   reg_rdata[ERR_EN-1:0] = err_en;
            A_ERR_STAT: reg_rdata[ERR_W-1:0]  = err_stat;
            A_EVT_EN:   reg_rdata[EVT_W-1:0]  = evt_en;
            default:    reg_rdata = '0;
        endcase
    end

    // R5: enabled, idle error line with an enabled raised class latches next edge.
    a_r5_err_latches: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en_q[IRQ_ERR] && !pending[IRQ_ERR] && ((err_en & err_stat[ERR_EN-1:0]) != '0))
        |=> pending[IRQ_ERR]);

    // R7: enabled, idle event line with a live enabled level latches next edge.
    a_r7_evt_latches: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en_q[IRQ_EVT] && !pending[IRQ_EVT] &&
         ((evt_en[EVT_RXFULL] && lvl_rx_full) || (evt_en[EVT_TXEMPTY] && lvl_tx_empty) ||
          (evt_en[EVT_READY] && lvl_ready)))
        |=> pending[IRQ_EVT]);

    // R3: an output is never high while its line is disabled.
    a_r3_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en_q[IRQ_EVT] |-> !irq_evt_o);
endmodule

// File: tb/spi_irq_hub_bench.sv
`timescale 1ns/1ps
module spi_irq_hub_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [5:0]  err_set_i = '0;
    logic        lvl_rx_full = 1'b0, lvl_tx_empty = 1'b0, lvl_ready = 1'b0;
    logic        irq_err_o, irq_evt_o;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    spi_irq_hub u_spi_irq_hub (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .err_set_i(err_set_i),
        .lvl_rx_full(lvl_rx_full), .lvl_tx_empty(lvl_tx_empty), .lvl_ready(lvl_ready),
        .irq_err_o(irq_err_o), .irq_evt_o(irq_evt_o)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    // Write one register; starts and ends on a falling edge.
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got 0x0 expected 0x1");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        rd(3'd0, d); check("R1 state", d, 32'h0);
        rd(3'd1, d); check("R1 enable", d, 32'h0);
        rd(3'd3, d); check("R1 err enable", d, 32'h1F);
        rd(3'd4, d); check("R1 err status", d, 32'h0);
        rd(3'd5, d); check("R1 evt enable", d, 32'h0);
        check("R1 outputs", {irq_err_o, irq_evt_o}, 32'h0);

        // R2 read-back and write masking
        wr(3'd3, 32'hFFFF_FFEA); rd(3'd3, d); check("R2 err enable", d, 32'h0A);
        wr(3'd5, 32'hFFFF_FFED); rd(3'd5, d); check("R2 evt enable", d, 32'h2D);
        wr(3'd5, 32'h0);
        wr(3'd1, 32'hFFFF_FFFC); rd(3'd1, d); check("R2 irq enable", d, 32'h0);
        rd(3'd2, d); check("R2 test reads zero", d, 32'h0);
        rd(3'd7, d); check("R2 hole reads zero", d, 32'h0);

        // R4 test write while disabled has no effect
        wr(3'd2, 32'h3); rd(3'd0, d); check("R4 test while disabled", d, 32'h0);
        // R4 test write with both enabled forces both
        wr(3'd1, 32'h3);
        wr(3'd2, 32'h3); rd(3'd0, d); check("R4 test forces", d, 32'h3);
        check("R3 outputs follow state", {irq_err_o, irq_evt_o}, 32'h3);
        // R3 clear only the event bit
        wr(3'd0, 32'h2); rd(3'd0, d); check("R3 w1c event", d, 32'h1);
        check("R3 event out low", irq_evt_o, 32'h0);
        // R9 disable error while pending
        wr(3'd1, 32'h2); rd(3'd0, d); check("R9 state kept", d, 32'h1);
        check("R9 output masked", irq_err_o, 32'h0);
        wr(3'd1, 32'h3); check("R9 output restored", irq_err_o, 32'h1);
        wr(3'd0, 32'h3); rd(3'd0, d); check("R3 w1c both", d, 32'h0);

        // R5/R6 sweep: every error enable mask against every class pulse
        wr(3'd1, 32'h1);
        for (int en = 0; en < 32; en++) begin
            for (int cls = 0; cls < 6; cls++) begin
                wr(3'd3, en);
                wr(3'd4, 32'h3F);
                wr(3'd0, 32'h3);
                err_set_i = 6'(1 << cls);
                @(negedge clk);
                err_set_i = '0;
                @(negedge clk);
                rd(3'd4, d); check("R6 pulse sets status", d, 32'(1 << cls));
                check("R5 error irq", irq_err_o,
                      32'((cls < 5) && ((en >> cls) & 1)));
            end
        end
        wr(3'd4, 32'h3F); wr(3'd0, 32'h3);

        // R6 pulse and clear in the same cycle: pulse wins
        err_set_i = 6'h04; @(negedge clk); err_set_i = '0;
        err_set_i = 6'h02; reg_we = 1'b1; reg_addr = 3'd4; reg_wdata = 32'h3F;
        @(negedge clk);
        err_set_i = '0; reg_we = 1'b0; reg_wdata = '0;
        rd(3'd4, d); check("R6 pulse beats clear", d, 32'h02);

        // R8 hold: pending survives its cause going away
        wr(3'd3, 32'h1F); wr(3'd0, 32'h3);
        @(negedge clk);
        rd(3'd0, d); check("R8 latched", d, 32'h1);
        wr(3'd4, 32'h3F);
        @(negedge clk);
        rd(3'd0, d); check("R8 held without cause", d, 32'h1);
        wr(3'd0, 32'h3);
        @(negedge clk);
        rd(3'd0, d); check("R8 stays clear", d, 32'h0);

        // R7 sweep: every event enable mask against every level combination
        wr(3'd1, 32'h2);
        for (int e = 0; e < 64; e++) begin
            for (int c = 0; c < 8; c++) begin
                wr(3'd5, 32'h0);
                lvl_rx_full = c[0]; lvl_tx_empty = c[1]; lvl_ready = c[2];
                wr(3'd0, 32'h3);
                wr(3'd5, e);
                @(negedge clk);
                rd(3'd0, d);
                check("R7 event latch", d,
                      32'(((e & 1) && c[0]) || (((e >> 1) & 1) && c[1]) || (((e >> 4) & 1) && c[2])) << 1);
                check("R7 event output", irq_evt_o, 32'(d[1]));
            end
        end

        // R8 re-latch after clear while cause persists
        wr(3'd5, 32'h01); lvl_rx_full = 1'b1; lvl_tx_empty = 1'b0; lvl_ready = 1'b0;
        @(negedge clk);
        wr(3'd0, 32'h2);
        rd(3'd0, d); check("R8 cleared", d, 32'h0);
        @(negedge clk);
        rd(3'd0, d); check("R8 relatched", d, 32'h2);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule